// File: doc/BRIEF.md
# Dual-Interface Pass-Through Mailbox Controller

This block governs a small shared SRAM mailbox that carries data one way between two hosts: a contactless (RF) side and a wired serial side. The mailbox holds 64 bytes and appears as sixteen 4-byte pages at addresses F0h through FFh. Each side has a simple page port. A request with a page address and a write flag gets a registered accept or busy response one cycle later. Accepted reads return the page contents.

Only one side owns the mailbox at a time. A direction bit decides which side is the writer (sender) and which is the reader (receiver). After enable or flush, the writer owns the buffer. When the owner completes its access to the last page (FFh), ownership passes to the other side. A sender can therefore fill only the last 4, 8, 12 or 16 pages and still hand the buffer over. Pass-through is switched on from the wired side, and only while both sides report power good. It drops by itself when either supply goes away. An optional protection flag makes the RF side need an authenticated input before its accesses are accepted.

Top module: `mbx_passthru`

## Requirements
- R1: Only page addresses F0h..FFh are accessible. A request to any other address is answered busy and changes neither memory nor ownership.
- R2: A wired-side configuration write with `cfg_enable`=1 sets pass-through only while `pwr_ok_rf` and `pwr_ok_ser` are both 1. While pass-through is off, every access is answered busy.
- R3: In the cycle after either power-good input is 0, `pt_enable` is 0.
- R4: With `pt_dir`=0 the RF side writes and the serial side reads. With `pt_dir`=1 the roles are swapped. A read by the writer or a write by the reader is answered busy.
- R5: Only the current owner is granted. After enable or flush the writer owns the buffer. `owner_ser`=1 means the serial side owns it. When both sides request in one cycle, at most the owner gets an accept.
- R6: An accepted write of page FFh moves ownership to the reader, sets `data_ready` and clears `buf_free`.
- R7: An accepted read of page FFh moves ownership back to the writer, sets `buf_free` and clears `data_ready`.
- R8: Accepted writes to pages below FFh keep ownership with the writer. Data written to pages FCh..FFh reads back unchanged on the other side.
- R9: While `prot_rf`=1 and `auth_rf`=0, every RF-side request is answered busy.
- R10: When pass-through is off, or a configuration write changes the direction bit, ownership returns to the writer and both status flags clear.
- R11: While `rst` is high the direction bit loads from `dir_por`, pass-through is off and all responses are 0.
- R12: The response to a request appears one cycle after it: `*_ok` or `*_busy`. Read data is valid only with ok. A busy or write response carries zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok_rf | input | 1 | RF side power good |
| pwr_ok_ser | input | 1 | Serial side power good |
| auth_rf | input | 1 | RF side authenticated |
| prot_rf | input | 1 | Protection flag for RF accesses |
| dir_por | input | 1 | Direction loaded during reset |
| cfg_we | input | 1 | Wired-side configuration write strobe |
| cfg_enable | input | 1 | Pass-through enable value to write |
| cfg_dir | input | 1 | Direction value to write |
| rf_req | input | 1 | RF page request |
| rf_we | input | 1 | RF request is a write |
| rf_page | input | 8 | RF page address |
| rf_wdata | input | 32 | RF write data |
| rf_ok | output | 1 | RF request accepted (registered) |
| rf_busy | output | 1 | RF request rejected (registered) |
| rf_rdata | output | 32 | RF read data |
| ser_req | input | 1 | Serial page request |
| ser_we | input | 1 | Serial request is a write |
| ser_page | input | 8 | Serial page address |
| ser_wdata | input | 32 | Serial write data |
| ser_ok | output | 1 | Serial request accepted (registered) |
| ser_busy | output | 1 | Serial request rejected (registered) |
| ser_rdata | output | 32 | Serial read data |
| pt_enable | output | 1 | Pass-through active |
| pt_dir | output | 1 | Current direction bit |
| owner_ser | output | 1 | Serial side owns the mailbox |
| data_ready | output | 1 | Buffer filled, reader may fetch |
| buf_free | output | 1 | Buffer drained, writer may refill |

## Verification
The bench attacks the points where ownership could be handed over wrongly. It writes pages below the terminator and then writes FFh. A design that handed over early would accept the reader's first read. One that never handed over would leave the reader busy indefinitely. The bench also sends simultaneous requests from both sides, a wrong-direction access by the owner, an out-of-window address, and an RF access under protection without authentication. In each case a faulty gate would show an accept where busy is due, or memory altered. Direction changes, disable and a power dip follow a half-finished transfer, so a design that kept stale ownership or flags would show the reader still owning or `data_ready` stuck high.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic {
        SIDE_RF  = 1'b0,
        SIDE_SER = 1'b1
    } side_e;

    typedef struct packed {
        logic ok;
        logic busy;
    } rsp_t;

    // Side that currently holds the mailbox; dir=0 means RF is the writer.
    function automatic side_e owner_of(logic dir, logic owner_writes);
        return side_e'(owner_writes ? dir : ~dir);
    endfunction

endpackage

// File: rtl/mbx_gate.sv
module mbx_gate #(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 4,
    parameter logic [ADDR_W-1:0] WIN_BASE = 8'hF0
) (
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] page,
    input  logic              enable,
    input  logic              is_owner,
    input  logic              owner_writes,
    input  logic              locked,
    output logic              grant,
    output logic              term,
    output logic [IDX_W-1:0]  idx
);
    logic in_win;

    always_comb begin
        in_win = (page[ADDR_W-1:IDX_W] == WIN_BASE[ADDR_W-1:IDX_W]);
        idx    = page[IDX_W-1:0];
        grant  = req && enable && in_win && is_owner && (we == owner_writes) && !locked;
        term   = grant && (&idx);
    end
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic dir_por,
    input  logic pwr_ok_rf,
    input  logic pwr_ok_ser,
    input  logic cfg_we,
    input  logic cfg_enable,
    input  logic cfg_dir,
    input  logic term_hit,
    output logic enable,
    output logic dir,
    output logic owner_writes,
    output logic data_ready,
    output logic buf_free
);
    logic en_n, dir_n, ow_n, rdy_n, free_n, both_pwr;

    always_comb begin
        both_pwr = pwr_ok_rf && pwr_ok_ser;
        ow_n     = owner_writes;
        rdy_n    = data_ready;
        free_n   = buf_free;
        if (term_hit) begin
            ow_n   = ~owner_writes;
            rdy_n  = owner_writes;
            free_n = ~owner_writes;
        end
        en_n  = cfg_we ? cfg_enable : enable;
        dir_n = cfg_we ? cfg_dir : dir;
        if (!both_pwr) en_n = 1'b0;
        if (!en_n || (dir_n != dir)) begin
            ow_n   = 1'b1;
            rdy_n  = 1'b0;
            free_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable       <= 1'b0;
            dir          <= dir_por;
            owner_writes <= 1'b1;
            data_ready   <= 1'b0;
            buf_free     <= 1'b0;
        end else begin
            enable       <= en_n;
            dir          <= dir_n;
            owner_writes <= ow_n;
            data_ready   <= rdy_n;
            buf_free     <= free_n;
        end
    end
endmodule

// File: rtl/mbx_store.sv
module mbx_store
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PAGES  = 16,
    localparam int IDX_W = $clog2(PAGES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        req,
    input  logic [1:0]        we,
    input  logic [1:0]        grant,
    input  logic [IDX_W-1:0]  idx   [2],
    input  logic [DATA_W-1:0] wdata [2],
    output rsp_t              rsp   [2],
    output logic [DATA_W-1:0] rdata [2]
);
    logic [DATA_W-1:0] mem [PAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < PAGES; p++) mem[p] <= '0;
        end else begin
            for (int s = 0; s < 2; s++)
                if (grant[s] && we[s]) mem[idx[s]] <= wdata[s];
        end
    end

    for (genvar s = 0; s < 2; s++) begin : g_port
        always_ff @(posedge clk) begin
            if (rst) begin
                rsp[s]   <= '0;
                rdata[s] <= '0;
            end else begin
                rsp[s].ok   <= grant[s];
                rsp[s].busy <= req[s] && !grant[s];
                rdata[s]    <= (grant[s] && !we[s]) ? mem[idx[s]] : '0;
            end
        end
    end
endmodule

// File: rtl/mbx_passthru.sv
module mbx_passthru
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int PAGES  = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 8'hF0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_ok_rf,
    input  logic              pwr_ok_ser,
    input  logic              auth_rf,
    input  logic              prot_rf,
    input  logic              dir_por,
    input  logic              cfg_we,
    input  logic              cfg_enable,
    input  logic              cfg_dir,
    input  logic              rf_req,
    input  logic              rf_we,
    input  logic [ADDR_W-1:0] rf_page,
    input  logic [DATA_W-1:0] rf_wdata,
    output logic              rf_ok,
    output logic              rf_busy,
    output logic [DATA_W-1:0] rf_rdata,
    input  logic              ser_req,
    input  logic              ser_we,
    input  logic [ADDR_W-1:0] ser_page,
    input  logic [DATA_W-1:0] ser_wdata,
    output logic              ser_ok,
    output logic              ser_busy,
    output logic [DATA_W-1:0] ser_rdata,
    output logic              pt_enable,
    output logic              pt_dir,
    output logic              owner_ser,
    output logic              data_ready,
    output logic              buf_free
);
    localparam int IDX_W = $clog2(PAGES);

    logic              owner_writes;
    side_e             owner;
    logic [1:0]        req_v, we_v, grant_v, term_v, own_v, lock_v;
    logic [ADDR_W-1:0] page_v  [2];
    logic [DATA_W-1:0] wdata_v [2];
    logic [DATA_W-1:0] rdata_v [2];
    logic [IDX_W-1:0]  idx_v   [2];
    rsp_t              rsp_v   [2];

    always_comb begin
        owner      = owner_of(pt_dir, owner_writes);
        owner_ser  = (owner == SIDE_SER);
        req_v      = {ser_req, rf_req};
        we_v       = {ser_we, rf_we};
        page_v[0]  = rf_page;
        page_v[1]  = ser_page;
        wdata_v[0] = rf_wdata;
        wdata_v[1] = ser_wdata;
        own_v      = {owner_ser, ~owner_ser};
        lock_v     = {1'b0, prot_rf & ~auth_rf};
    end

    for (genvar s = 0; s < 2; s++) begin : g_gate
        mbx_gate #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .WIN_BASE(WIN_BASE)) u_gate (
            .req(req_v[s]), .we(we_v[s]), .page(page_v[s]), .enable(pt_enable),
            .is_owner(own_v[s]), .owner_writes(owner_writes), .locked(lock_v[s]),
            .grant(grant_v[s]), .term(term_v[s]), .idx(idx_v[s])
        );
    end

    mbx_ctrl u_ctrl (
        .clk(clk), .rst(rst), .dir_por(dir_por),
        .pwr_ok_rf(pwr_ok_rf), .pwr_ok_ser(pwr_ok_ser),
        .cfg_we(cfg_we), .cfg_enable(cfg_enable), .cfg_dir(cfg_dir),
        .term_hit(|term_v), .enable(pt_enable), .dir(pt_dir),
        .owner_writes(owner_writes), .data_ready(data_ready), .buf_free(buf_free)
    );

    mbx_store #(.DATA_W(DATA_W), .PAGES(PAGES)) u_store (
        .clk(clk), .rst(rst), .req(req_v), .we(we_v), .grant(grant_v),
        .idx(idx_v), .wdata(wdata_v), .rsp(rsp_v), .rdata(rdata_v)
    );

    always_comb begin
        rf_ok     = rsp_v[0].ok;
        rf_busy   = rsp_v[0].busy;
        ser_ok    = rsp_v[1].ok;
        ser_busy  = rsp_v[1].busy;
        rf_rdata  = rdata_v[0];
        ser_rdata = rdata_v[1];
    end
endmodule

// File: rtl/mbx_passthru_chk.sv
module mbx_passthru_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              pwr_ok_rf,
    input logic              pwr_ok_ser,
    input logic              auth_rf,
    input logic              prot_rf,
    input logic              rf_req,
    input logic              ser_req,
    input logic              rf_ok,
    input logic              rf_busy,
    input logic [DATA_W-1:0] rf_rdata,
    input logic              ser_ok,
    input logic              ser_busy,
    input logic [DATA_W-1:0] ser_rdata,
    input logic              pt_enable,
    input logic              data_ready
);
    assert_single_grant_R5: assert property (@(posedge clk) disable iff (rst)
        rf_ok |-> !ser_ok);

    assert_power_drop_R3: assert property (@(posedge clk) disable iff (rst)
        !(pwr_ok_rf && pwr_ok_ser) |=> !pt_enable);

    assert_protect_R9: assert property (@(posedge clk) disable iff (rst)
        (prot_rf && !auth_rf && rf_req) |=> rf_busy);

    assert_off_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (!pt_enable && ser_req) |=> ser_busy);

    assert_blocked_zero_R12: assert property (@(posedge clk) disable iff (rst)
        (rf_busy |-> rf_rdata == '0) and (ser_busy |-> ser_rdata == '0));

    assert_ready_needs_enable_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(data_ready) |-> $past(pt_enable));
endmodule

bind mbx_passthru mbx_passthru_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .pwr_ok_rf(pwr_ok_rf), .pwr_ok_ser(pwr_ok_ser),
    .auth_rf(auth_rf), .prot_rf(prot_rf), .rf_req(rf_req), .ser_req(ser_req),
    .rf_ok(rf_ok), .rf_busy(rf_busy), .rf_rdata(rf_rdata),
    .ser_ok(ser_ok), .ser_busy(ser_busy), .ser_rdata(ser_rdata),
    .pt_enable(pt_enable), .data_ready(data_ready)
);

// File: tb/mbx_passthru_bench.sv
module mbx_passthru_bench;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst = 1'b1, pwr_ok_rf = 1'b0, pwr_ok_ser = 1'b0, auth_rf = 1'b0, prot_rf = 1'b0;
    logic dir_por = 1'b0, cfg_we = 1'b0, cfg_enable = 1'b0, cfg_dir = 1'b0;
    logic rf_req = 1'b0, rf_we = 1'b0, ser_req = 1'b0, ser_we = 1'b0;
    logic [7:0]  rf_page = '0, ser_page = '0;
    logic [31:0] rf_wdata = '0, ser_wdata = '0;
    logic rf_ok, rf_busy, ser_ok, ser_busy, pt_enable, pt_dir, owner_ser, data_ready, buf_free;
    logic [31:0] rf_rdata, ser_rdata;

    mbx_passthru u_mbx_passthru (.*);

    int    n_cmp = 0, n_bad = 0;
    string cur_req = "R11";
    bit    done = 0;

    // behavioural reference state
    bit          m_en, m_dir, m_ownw = 1, m_rdy, m_free;
    bit          m_ok [2], m_busy [2];
    logic [31:0] m_rd [2];
    logic [31:0] m_mem [16];

    function automatic void model_step();
        bit pg, term, new_en, new_dir;
        int own_side;
        bit rq [2]; bit wq [2]; logic [7:0] pq [2]; logic [31:0] dq [2];
        rq[0] = rf_req;  wq[0] = rf_we;  pq[0] = rf_page;  dq[0] = rf_wdata;
        rq[1] = ser_req; wq[1] = ser_we; pq[1] = ser_page; dq[1] = ser_wdata;
        if (rst) begin
            m_en = 0; m_dir = dir_por; m_ownw = 1; m_rdy = 0; m_free = 0;
            for (int s = 0; s < 2; s++) begin m_ok[s] = 0; m_busy[s] = 0; m_rd[s] = 0; end
            for (int p = 0; p < 16; p++) m_mem[p] = 0;
            return;
        end
        pg = pwr_ok_rf && pwr_ok_ser;
        own_side = m_ownw ? int'(m_dir) : int'(!m_dir);
        term = 0;
        for (int s = 0; s < 2; s++) begin
            bit acc;
            acc = rq[s] && m_en && (pq[s] >= 8'hF0) && (own_side == s) && (wq[s] == m_ownw)
                  && !(s == 0 && prot_rf && !auth_rf);
            m_ok[s] = acc;
            m_busy[s] = rq[s] && !acc;
            m_rd[s] = (acc && !wq[s]) ? m_mem[pq[s] - 8'hF0] : 32'h0;
            if (acc && wq[s]) m_mem[pq[s] - 8'hF0] = dq[s];
            if (acc && pq[s] == 8'hFF) term = 1;
        end
        if (term) begin
            m_rdy = m_ownw; m_free = !m_ownw; m_ownw = !m_ownw;
        end
        new_en = cfg_we ? cfg_enable : m_en;
        new_dir = cfg_we ? cfg_dir : m_dir;
        if (!pg) new_en = 0;
        if (!new_en || new_dir != m_dir) begin m_ownw = 1; m_rdy = 0; m_free = 0; end
        m_en = new_en; m_dir = new_dir;
    endfunction

    task automatic compare();
        logic [72:0] act, exp;
        bit eo;
        eo  = m_ownw ? m_dir : !m_dir;
        act = {pt_enable, pt_dir, owner_ser, data_ready, buf_free, rf_ok, rf_busy,
               ser_ok, ser_busy, rf_rdata, ser_rdata};
        exp = {m_en, m_dir, eo, m_rdy, m_free, m_ok[0], m_busy[0], m_ok[1], m_busy[1],
               m_rd[0], m_rd[1]};
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s t=%0t actual=%h expected=%h", cur_req, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        model_step();
        #1 compare();
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(bit en, bit d);
        cfg_we = 1; cfg_enable = en; cfg_dir = d; tick(); cfg_we = 0;
    endtask

    task automatic rf_acc(bit w, logic [7:0] p, logic [31:0] d = 0);
        rf_req = 1; rf_we = w; rf_page = p; rf_wdata = d; tick(); rf_req = 0;
    endtask

    task automatic ser_acc(bit w, logic [7:0] p, logic [31:0] d = 0);
        ser_req = 1; ser_we = w; ser_page = p; ser_wdata = d; tick(); ser_req = 0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        tick(3);
        rst = 0; cur_req = "R11"; tick(2);
        // R2: enable refused without both supplies; accesses busy while off
        cur_req = "R2"; pwr_ok_ser = 1; cfg(1, 0); tick();
        rf_acc(1, 8'hF0, 32'h1111_0000); tick();
        pwr_ok_rf = 1; cfg(1, 0); tick();
        // R4 R5: reader before handover, writer reading
        cur_req = "R4 R5"; ser_acc(0, 8'hFC); rf_acc(0, 8'hF0); ser_acc(1, 8'hF0, 32'hDEAD); tick();
        // R1: out-of-window address
        cur_req = "R1"; rf_acc(1, 8'hEF, 32'hBAD0); rf_acc(1, 8'h00, 32'hBAD1); tick();
        // R8 R6: 16-byte transfer using last four pages
        cur_req = "R8 R6";
        for (int i = 0; i < 4; i++) rf_acc(1, 8'hFC + 8'(i), 32'hA5A5_0000 + i);
        tick();
        cur_req = "R12"; rf_acc(1, 8'hFC, 32'h0); rf_acc(0, 8'hFC); tick();
        cur_req = "R7 R8";
        for (int i = 0; i < 4; i++) ser_acc(0, 8'hFC + 8'(i));
        tick();
        // R5: simultaneous requests, only owner (RF writer) granted
        cur_req = "R5";
        rf_req = 1; rf_we = 1; rf_page = 8'hFE; rf_wdata = 32'h5151;
        ser_req = 1; ser_we = 0; ser_page = 8'hFE; tick(); rf_req = 0; ser_req = 0; tick();
        // R9: protection without and with authentication
        cur_req = "R9"; prot_rf = 1; rf_acc(1, 8'hFF, 32'h9999); tick();
        auth_rf = 1; rf_acc(1, 8'hFF, 32'h7777); tick(); prot_rf = 0; auth_rf = 0;
        // R10: direction change flushes pending handover
        cur_req = "R10"; cfg(1, 1); tick();
        cur_req = "R4 R6 R7"; ser_acc(1, 8'hFF, 32'hC0DE); rf_acc(0, 8'hFF); ser_acc(0, 8'hFF); tick();
        cur_req = "R10"; ser_acc(1, 8'hFF, 32'hFACE); cfg(0, 1); tick(); cfg(1, 1); tick();
        // R3: power dip drops enable and it stays off
        cur_req = "R3"; ser_acc(1, 8'hFF, 32'h3333); pwr_ok_rf = 0; tick(2); pwr_ok_rf = 1; tick(2);
        ser_acc(1, 8'hF0, 32'h4444); tick();
        // R11: reset default direction from either side
        cur_req = "R11"; rst = 1; dir_por = 1; tick(2); rst = 0; tick(2);
        done = 1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end
endmodule